// File: doc/BRIEF.md
# 24-bit Memory Map Decoder

This block turns the 24-bit address of a 16-bit-capable processor into chip selects for the board's memories. The targets are three 512 KiB fast RAM banks, a 512 KiB on-board flash ROM, an expansion-bus memory window, a bus video window and a bus I/O select. The processor multiplexes its top eight address bits onto the data bus while the Phi2 clock is low, so the decoder captures them into a bank register during that phase. All decoding is done during the following Phi2-high phase.

The lowest 64 KiB are steered by a write-only control register. Depending on its bits, these addresses go to the bottom of the ROM, to the expansion bus or to fast RAM. Two windows are fixed whatever the register holds: video and I/O always go to the bus. Any bank-0 write that reaches the bus or the ROM is also copied into fast RAM, unless a 2-bit protection code guards that address.

The decoder also gives the fast-RAM address, a write-through flag, a slow-target flag for the wait-state logic, a ROM write enable and a remapped bus address for the video window. The wait-state logic, the clocking and the devices themselves are outside this block.

Top module: `memdec_top`

## Requirements
- R1: On every rising clock edge while `phi2` is low, `data_in` is loaded into the bank register that forms address bits 23:16. While `phi2` is high the bank register holds. While `phi2` is low none of `ram_rd`, `ram_wr`, `rom_rd`, `rom_we`, `bus_sel` is asserted.
- R2: The control register is loaded from `data_in` by a write (`rw_n`=0) while `phi2` is high to $00EBFF, or to $00EFFF instead when `reloc_jmp`=1. A write to the other address leaves it unchanged. Bit 7 enables ROM writes, bit 6 maps bank 0 to ROM, bit 5 maps bank 0 to the bus, bit 4 forces slow access, bit 3 drives `hide_bogus`, bit 2 serves video reads from RAM, and bits 1:0 select write protection. At reset the register holds bit 6 = `boot_jmp`, bits 5..2 = 1 and bits 7, 1 and 0 = 0.
- R3: In bank 0, outside the video and I/O windows, an access goes to ROM when bit 6 = 1 (ROM address = low 16 address bits). Otherwise it goes to the bus when bit 5 = 1, and otherwise to fast RAM. Bit 6 wins when both bits are set.
- R4: $008000–$0087FF goes to the bus with `bus_addr` = $018000–$0187FF. When bit 2 = 1, reads there assert `ram_rd` at the same address instead, while writes still go to the bus.
- R5: $00E800–$00EFFF goes to the bus with `bus_io_sel`=1 and `bus_addr` equal to the processor address.
- R6: A bank-0 write whose target is the bus or ROM also asserts `ram_wr` and `write_through`, with `ram_addr` equal to the processor address, unless R7 blocks it.
- R7: A bank-0 write to fast RAM (direct or written through) is blocked from offset $A000 up for code 01, from $C000 up for code 10, and from $E000 up for code 11. Code 00 blocks nothing.
- R8: Banks $01–$17 are fast RAM with `ram_addr` = address bits 20:0, and banks $E0–$EF are bus memory. `ram_bank_sel` is one-hot at index `ram_addr[20:19]` whenever `ram_rd` or `ram_wr` is asserted.
- R9: Banks $F0–$F7 reach fast RAM with `ram_addr` = address bits 18:0 and `ram_addr[20:19]` = 0.
- R10: Banks $F8–$FF are ROM with `rom_addr` = address bits 18:0. Reads assert `rom_rd`. `rom_we` is asserted only on a ROM-target write while control bit 7 = 1.
- R11: Banks $18–$DF assert no select, no write enable and no flag.
- R12: At most one of `ram_rd`, `rom_rd` and a bus read (`bus_sel` with `rw_n`=1) is active at a time.
- R13: `slow` is asserted for every bus or ROM access, and for fast-RAM accesses only while control bit 4 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_jmp | input | 1 | Reset value of the boot-from-ROM bit |
| reloc_jmp | input | 1 | Moves the control register to $00EFFF |
| phi2 | input | 1 | Processor phase: low = bank on data bus, high = access |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr_lo | input | 16 | Address bits 15:0 |
| data_in | input | 8 | Processor data bus |
| ram_rd | output | 1 | Fast RAM read select |
| ram_wr | output | 1 | Fast RAM write enable |
| ram_bank_sel | output | 3 | One-hot fast RAM bank select |
| ram_addr | output | 21 | Fast RAM address |
| rom_rd | output | 1 | ROM read select |
| rom_we | output | 1 | ROM write enable |
| rom_addr | output | 19 | ROM address |
| bus_sel | output | 1 | Expansion bus access select |
| bus_io_sel | output | 1 | Bus I/O select |
| bus_addr | output | 24 | Address presented to the bus |
| write_through | output | 1 | RAM write accompanies a bus or ROM write |
| slow | output | 1 | Access needs bus-speed timing |
| hide_bogus | output | 1 | Control bit 3, for the cycle-hiding logic |

## Verification
Several rules are checked on every cycle. The bank register holds through Phi2 high, and no select fires during Phi2 low. The read selects are mutually exclusive, the I/O select stays inside bank 0, write-through only accompanies a bank-0 RAM write, and ROM writes need the program bit. Unmapped banks stay silent, and the control register changes only after a write to one of its two addresses. The bench scenarios are needed for the rest: the reset value taken from the jumper, the precedence between the bank-0 steering bits, the relocate jumper, the exact protection boundaries for each code, the video remap and its read-from-RAM option, the mirror and bank-select addresses, and the slow flag following the slow-clock bit.

// File: rtl/memdec_pkg.sv
// Shared types and fixed address-map constants of the memory map decoder.
// Assumes a 24-bit address split as an 8-bit bank and a 16-bit offset.
package memdec_pkg;

    typedef struct packed {
        logic       rom_prog;     // bit 7: allow ROM writes
        logic       boot_rom;     // bit 6: bank 0 -> ROM
        logic       low_bus;      // bit 5: bank 0 -> bus
        logic       slow_all;     // bit 4: slow timing everywhere
        logic       hide_cyc;     // bit 3: hide dead cycles
        logic       vid_rd_fast;  // bit 2: video reads from fast RAM
        logic [1:0] wprot;        // bits 1:0: protection code
    } ctrl_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_BUS  = 2'd3
    } tgt_e;

    localparam logic [4:0]  VID_TAG      = 5'b10000;   // $8000-$87FF
    localparam logic [4:0]  IO_TAG       = 5'b11101;   // $E800-$EFFF
    localparam logic [15:0] CTRL_OFS     = 16'hEBFF;
    localparam logic [15:0] CTRL_OFS_ALT = 16'hEFFF;
    localparam logic [7:0]  VID_BUS_BANK = 8'h01;

    // Reset value of the control register for a given boot jumper.
    function automatic ctrl_t ctrl_reset(input logic boot);
        ctrl_t c;
        c.rom_prog    = 1'b0;
        c.boot_rom    = boot;
        c.low_bus     = 1'b1;
        c.slow_all    = 1'b1;
        c.hide_cyc    = 1'b1;
        c.vid_rd_fast = 1'b1;
        c.wprot       = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/memdec_bank_latch.sv
// Bank capture: samples the high address byte from the data bus on each
// clock edge while phi2 is low and holds it through phi2 high.
// Assumes the bus carries the bank byte throughout phi2 low.
module memdec_bank_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] bank_q
);

    // Load during the address phase, hold during the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (!phi2)
            bank_q <= data_in;
    end

endmodule

// File: rtl/memdec_ctrl_reg.sv
// Write-only control register at one of two bank-0 offsets chosen by a
// jumper. Assumes write data is stable on the bus while phi2 is high.
module memdec_ctrl_reg
    import memdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boot_jmp,
    input  logic        reloc_jmp,
    input  logic        phi2,
    input  logic        rw_n,
    input  logic [7:0]  bank,
    input  logic [15:0] addr_lo,
    input  logic [7:0]  data_in,
    output ctrl_t       ctrl_q
);

    logic [15:0] reg_ofs;
    logic        hit;

    // Pick the register offset and detect a write to it.
    always_comb begin
        reg_ofs = reloc_jmp ? CTRL_OFS_ALT : CTRL_OFS;
        hit     = phi2 && !rw_n && (bank == 8'h00) && (addr_lo == reg_ofs);
    end

    // Reset from the jumper, otherwise load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= ctrl_reset(boot_jmp);
        else if (hit)
            ctrl_q <= ctrl_t'(data_in);
    end

endmodule

// File: rtl/memdec_route.sv
// Target selection: classifies the current address as fast RAM, ROM, bus
// or unmapped, flags the fixed bank-0 windows and the protected range.
// Purely combinational; assumes bank and offset are valid in phi2 high.
module memdec_route
    import memdec_pkg::*;
#(
    parameter int RAM_BANKS = 3,
    parameter int BANK_AW   = 19
) (
    input  logic [7:0]  bank,
    input  logic [15:0] addr_lo,
    input  logic        rw_n,
    input  ctrl_t       ctrl,
    output tgt_e        tgt,
    output logic        is_bank0,
    output logic        is_vid,
    output logic        is_io,
    output logic        is_mirror,
    output logic        wr_block
);

    localparam int          BANKS_PER_RAM = 2 ** (BANK_AW - 16);
    localparam logic [7:0]  RAM_TOP_BANK  = 8'(RAM_BANKS * BANKS_PER_RAM - 1);

    // Window flags for the current address.
    always_comb begin
        is_bank0  = (bank == 8'h00);
        is_vid    = is_bank0 && (addr_lo[15:11] == VID_TAG);
        is_io     = is_bank0 && (addr_lo[15:11] == IO_TAG);
        is_mirror = (bank[7:4] == 4'hF) && !bank[3];
    end

    // Target decision with the bank-0 steering precedence.
    always_comb begin
        tgt = TGT_NONE;
        if (is_bank0) begin
            if (is_vid)
                tgt = (rw_n && ctrl.vid_rd_fast) ? TGT_RAM : TGT_BUS;
            else if (is_io)
                tgt = TGT_BUS;
            else if (ctrl.boot_rom)
                tgt = TGT_ROM;
            else if (ctrl.low_bus)
                tgt = TGT_BUS;
            else
                tgt = TGT_RAM;
        end else if (bank <= RAM_TOP_BANK) begin
            tgt = TGT_RAM;
        end else if (bank[7:4] == 4'hE) begin
            tgt = TGT_BUS;
        end else if (is_mirror) begin
            tgt = TGT_RAM;
        end else if (bank[7:3] == 5'b11111) begin
            tgt = TGT_ROM;
        end
    end

    // Protected range of bank-0 fast RAM for the selected code.
    always_comb begin
        unique case (ctrl.wprot)
            2'b01:   wr_block = is_bank0 && (addr_lo >= 16'hA000);
            2'b10:   wr_block = is_bank0 && (addr_lo >= 16'hC000);
            2'b11:   wr_block = is_bank0 && (addr_lo >= 16'hE000);
            default: wr_block = 1'b0;
        endcase
    end

endmodule

// File: rtl/memdec_select.sv
// Output stage: turns the chosen target into qualified selects, addresses
// and flags. All selects are gated by phi2 high. Combinational.
module memdec_select
    import memdec_pkg::*;
#(
    parameter int RAM_BANKS = 3,
    parameter int BANK_AW   = 19,
    parameter int ROM_AW    = 19
) (
    input  logic                            phi2,
    input  logic                            rw_n,
    input  logic [7:0]                      bank,
    input  logic [15:0]                     addr_lo,
    input  tgt_e                            tgt,
    input  logic                            is_bank0,
    input  logic                            is_vid,
    input  logic                            is_io,
    input  logic                            is_mirror,
    input  logic                            wr_block,
    input  logic                            rom_prog,
    input  logic                            slow_all,
    output logic                            ram_rd,
    output logic                            ram_wr,
    output logic [RAM_BANKS-1:0]            ram_bank_sel,
    output logic [BANK_AW+$clog2(RAM_BANKS)-1:0] ram_addr,
    output logic                            rom_rd,
    output logic                            rom_we,
    output logic [ROM_AW-1:0]               rom_addr,
    output logic                            bus_sel,
    output logic                            bus_io_sel,
    output logic [23:0]                     bus_addr,
    output logic                            write_through,
    output logic                            slow
);

    localparam int SEL_W  = $clog2(RAM_BANKS);
    localparam int RAM_AW = BANK_AW + SEL_W;

    logic [23:0] full_addr;
    logic        ram_hit;

    // Select and enable generation for the chosen target.
    always_comb begin
        full_addr     = {bank, addr_lo};
        ram_hit       = (tgt == TGT_RAM);
        ram_rd        = phi2 && rw_n && ram_hit;
        ram_wr        = phi2 && !rw_n && !wr_block && (ram_hit || is_bank0);
        write_through = ram_wr && !ram_hit;
        rom_rd        = phi2 && rw_n && (tgt == TGT_ROM);
        rom_we        = phi2 && !rw_n && (tgt == TGT_ROM) && rom_prog;
        bus_sel       = phi2 && (tgt == TGT_BUS);
        bus_io_sel    = phi2 && is_io;
        slow          = phi2 && (tgt != TGT_NONE) && (slow_all || !ram_hit);
    end

    // Address formation for each device.
    always_comb begin
        bus_addr = is_vid ? {VID_BUS_BANK, addr_lo} : full_addr;
        rom_addr = full_addr[ROM_AW-1:0];
        if (is_mirror)
            ram_addr = RAM_AW'(full_addr[BANK_AW-1:0]);
        else
            ram_addr = full_addr[RAM_AW-1:0];
    end

    // One bank select per fast RAM device.
    for (genvar i = 0; i < RAM_BANKS; i++) begin : g_bank
        assign ram_bank_sel[i] = (ram_rd || ram_wr) &&
                                 (ram_addr[RAM_AW-1:BANK_AW] == SEL_W'(i));
    end

endmodule

// File: rtl/memdec_top.sv
// Memory map decoder top: bank capture, control register, target routing
// and output stage. Assumes the processor drives the bank byte in phi2 low.
module memdec_top
    import memdec_pkg::*;
#(
    parameter int RAM_BANKS = 3,
    parameter int BANK_AW   = 19,
    parameter int ROM_AW    = 19,
    localparam int RAM_AW   = BANK_AW + $clog2(RAM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_jmp,
    input  logic                 reloc_jmp,
    input  logic                 phi2,
    input  logic                 rw_n,
    input  logic [15:0]          addr_lo,
    input  logic [7:0]           data_in,
    output logic                 ram_rd,
    output logic                 ram_wr,
    output logic [RAM_BANKS-1:0] ram_bank_sel,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 rom_rd,
    output logic                 rom_we,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic                 bus_sel,
    output logic                 bus_io_sel,
    output logic [23:0]          bus_addr,
    output logic                 write_through,
    output logic                 slow,
    output logic                 hide_bogus
);

    logic [7:0] bank_q;
    ctrl_t      ctrl_q;
    tgt_e       tgt;
    logic       is_bank0, is_vid, is_io, is_mirror, wr_block;

    memdec_bank_latch #(.DATA_W(8)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi2    (phi2),
        .data_in (data_in),
        .bank_q  (bank_q)
    );

    memdec_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_jmp  (boot_jmp),
        .reloc_jmp (reloc_jmp),
        .phi2      (phi2),
        .rw_n      (rw_n),
        .bank      (bank_q),
        .addr_lo   (addr_lo),
        .data_in   (data_in),
        .ctrl_q    (ctrl_q)
    );

    memdec_route #(.RAM_BANKS(RAM_BANKS), .BANK_AW(BANK_AW)) u_route (
        .bank      (bank_q),
        .addr_lo   (addr_lo),
        .rw_n      (rw_n),
        .ctrl      (ctrl_q),
        .tgt       (tgt),
        .is_bank0  (is_bank0),
        .is_vid    (is_vid),
        .is_io     (is_io),
        .is_mirror (is_mirror),
        .wr_block  (wr_block)
    );

    memdec_select #(.RAM_BANKS(RAM_BANKS), .BANK_AW(BANK_AW), .ROM_AW(ROM_AW)) u_sel (
        .phi2          (phi2),
        .rw_n          (rw_n),
        .bank          (bank_q),
        .addr_lo       (addr_lo),
        .tgt           (tgt),
        .is_bank0      (is_bank0),
        .is_vid        (is_vid),
        .is_io         (is_io),
        .is_mirror     (is_mirror),
        .wr_block      (wr_block),
        .rom_prog      (ctrl_q.rom_prog),
        .slow_all      (ctrl_q.slow_all),
        .ram_rd        (ram_rd),
        .ram_wr        (ram_wr),
        .ram_bank_sel  (ram_bank_sel),
        .ram_addr      (ram_addr),
        .rom_rd        (rom_rd),
        .rom_we        (rom_we),
        .rom_addr      (rom_addr),
        .bus_sel       (bus_sel),
        .bus_io_sel    (bus_io_sel),
        .bus_addr      (bus_addr),
        .write_through (write_through),
        .slow          (slow)
    );

    assign hide_bogus = ctrl_q.hide_cyc;

endmodule

// File: rtl/memdec_checker.sv
// Cycle-by-cycle properties of the memory map decoder, bound to the top.
module memdec_checker #(
    parameter int RAM_BANKS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 phi2,
    input logic                 rw_n,
    input logic [15:0]          addr_lo,
    input logic [7:0]           bank,
    input logic [7:0]           ctrl_bits,
    input logic                 ram_rd,
    input logic                 ram_wr,
    input logic [RAM_BANKS-1:0] ram_bank_sel,
    input logic                 rom_rd,
    input logic                 rom_we,
    input logic                 bus_sel,
    input logic                 bus_io_sel,
    input logic [23:0]          bus_addr,
    input logic                 write_through,
    input logic                 slow
);

    // R1
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && $past(phi2)) |-> $stable(bank));

    // R1
    phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> !(ram_rd || ram_wr || rom_rd || rom_we || bus_sel));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi2 && !rw_n && bank == 8'h00 &&
          (addr_lo == 16'hEBFF || addr_lo == 16'hEFFF)) |=> $stable(ctrl_bits));

    // R4
    vid_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bank == 8'h00 && addr_lo[15:11] == 5'b10000)
        |-> (bus_addr[23:16] == 8'h01));

    // R5
    io_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io_sel |-> (bus_sel && bank == 8'h00));

    // R6
    wthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_through |-> (ram_wr && !rw_n && bank == 8'h00));

    // R8
    bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd || ram_wr) |-> ($countones(ram_bank_sel) == 1));

    // R10
    rom_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_we |-> (ctrl_bits[7] && !rw_n));

    // R11
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && bank >= 8'h18 && bank <= 8'hDF)
        |-> !(ram_rd || ram_wr || rom_rd || rom_we || bus_sel || slow));

    // R12
    rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd, rom_rd, bus_sel && rw_n}));

    // R13
    slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel || rom_rd || rom_we) |-> slow);

endmodule

bind memdec_top memdec_checker #(.RAM_BANKS(RAM_BANKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phi2          (phi2),
    .rw_n          (rw_n),
    .addr_lo       (addr_lo),
    .bank          (bank_q),
    .ctrl_bits     (ctrl_q),
    .ram_rd        (ram_rd),
    .ram_wr        (ram_wr),
    .ram_bank_sel  (ram_bank_sel),
    .rom_rd        (rom_rd),
    .rom_we        (rom_we),
    .bus_sel       (bus_sel),
    .bus_io_sel    (bus_io_sel),
    .bus_addr      (bus_addr),
    .write_through (write_through),
    .slow          (slow)
);

// File: tb/memdec_top_tb.sv
// Scoreboard bench: the driver queues expected outputs per access, the
// monitor pops and compares them in the middle of the phi2-high phase.
module memdec_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_jmp = 1'b1;
    logic        reloc_jmp = 1'b0;
    logic        phi2 = 1'b0;
    logic        rw_n = 1'b1;
    logic [15:0] addr_lo = '0;
    logic [7:0]  data_in = '0;
    logic        ram_rd, ram_wr, rom_rd, rom_we, bus_sel, bus_io_sel;
    logic        write_through, slow, hide_bogus;
    logic [2:0]  ram_bank_sel;
    logic [20:0] ram_addr;
    logic [18:0] rom_addr;
    logic [23:0] bus_addr;

    int checks = 0;
    int errors = 0;
    bit pend = 1'b0;

    always #2.5 clk = ~clk;

    memdec_top u_dut (
        .clk(clk), .rst_n(rst_n), .boot_jmp(boot_jmp), .reloc_jmp(reloc_jmp),
        .phi2(phi2), .rw_n(rw_n), .addr_lo(addr_lo), .data_in(data_in),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_bank_sel(ram_bank_sel),
        .ram_addr(ram_addr), .rom_rd(rom_rd), .rom_we(rom_we),
        .rom_addr(rom_addr), .bus_sel(bus_sel), .bus_io_sel(bus_io_sel),
        .bus_addr(bus_addr), .write_through(write_through), .slow(slow),
        .hide_bogus(hide_bogus)
    );

    typedef struct {
        logic        ram_rd, ram_wr, rom_rd, rom_we, bus, io, wt, slow;
        logic [2:0]  bsel;
        logic [20:0] ra;
        logic [18:0] roa;
        logic [23:0] ba;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic exp_t ez();
        exp_t e;
        e.ram_rd = 0; e.ram_wr = 0; e.rom_rd = 0; e.rom_we = 0;
        e.bus = 0; e.io = 0; e.wt = 0; e.slow = 0;
        e.bsel = '0; e.ra = '0; e.roa = '0; e.ba = '0; e.tag = "";
        return e;
    endfunction

    function automatic exp_t eram(logic [20:0] a, bit rd, bit slw);
        exp_t e = ez();
        e.ram_rd = rd; e.ram_wr = !rd; e.ra = a;
        e.bsel = 3'b001 << a[20:19]; e.slow = slw;
        return e;
    endfunction

    function automatic exp_t erom(logic [18:0] a, bit rd, bit we);
        exp_t e = ez();
        e.rom_rd = rd; e.rom_we = we; e.roa = a; e.slow = 1;
        return e;
    endfunction

    function automatic exp_t ebus(logic [23:0] a, bit io);
        exp_t e = ez();
        e.bus = 1; e.io = io; e.ba = a; e.slow = 1;
        return e;
    endfunction

    function automatic exp_t ewt(exp_t ein, logic [20:0] a);
        exp_t e = ein;
        e.ram_wr = 1; e.ra = a; e.bsel = 3'b001 << a[20:19]; e.wt = 1;
        return e;
    endfunction

    task automatic cmp(string tag, string fld, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
        end
    endtask

    // One bus cycle: bank phase, then access phase; optionally scored.
    task automatic acc(string tag, logic [7:0] bk, logic [15:0] lo, bit rd,
                       logic [7:0] wd, exp_t e, bit chk);
        @(negedge clk);
        phi2 = 0; rw_n = 1; data_in = bk;
        @(negedge clk);
        phi2 = 1; addr_lo = lo; rw_n = rd; data_in = wd;
        if (chk) begin
            e.tag = tag;
            sb.push_back(e);
            pend = 1;
        end
        @(posedge clk);
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        acc("", 8'h00, reloc_jmp ? 16'hEFFF : 16'hEBFF, 0, v, ez(), 0);
    endtask

    // Monitor: compare the oldest expected item during phi2 high.
    always @(negedge clk) begin
        #1;
        if (pend) begin
            exp_t e;
            pend = 0;
            e = sb.pop_front();
            cmp(e.tag, "ram_rd", 24'(ram_rd), 24'(e.ram_rd));
            cmp(e.tag, "ram_wr", 24'(ram_wr), 24'(e.ram_wr));
            cmp(e.tag, "bank_sel", 24'(ram_bank_sel), 24'(e.bsel));
            cmp(e.tag, "rom_rd", 24'(rom_rd), 24'(e.rom_rd));
            cmp(e.tag, "rom_we", 24'(rom_we), 24'(e.rom_we));
            cmp(e.tag, "bus_sel", 24'(bus_sel), 24'(e.bus));
            cmp(e.tag, "bus_io_sel", 24'(bus_io_sel), 24'(e.io));
            cmp(e.tag, "write_through", 24'(write_through), 24'(e.wt));
            cmp(e.tag, "slow", 24'(slow), 24'(e.slow));
            if (e.ram_rd || e.ram_wr) cmp(e.tag, "ram_addr", 24'(ram_addr), 24'(e.ra));
            if (e.rom_rd || e.rom_we) cmp(e.tag, "rom_addr", 24'(rom_addr), 24'(e.roa));
            if (e.bus) cmp(e.tag, "bus_addr", bus_addr, e.ba);
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R2 R3: reset with boot jumper set -> bank 0 from ROM
        acc("R2 R3 reset boot rom read", 8'h00, 16'h1000, 1, 8'h00, erom(19'h01000, 1, 0), 1);
        acc("R6 R10 rom write through", 8'h00, 16'h3000, 0, 8'h11, ewt(erom(19'h03000, 0, 0), 21'h003000), 1);
        @(negedge clk); #1;
        cmp("R2 reset hide_bogus", "hide_bogus", 24'(hide_bogus), 24'd1);

        // R1: selects idle while phi2 low with a RAM bank on the bus
        @(negedge clk); phi2 = 0; rw_n = 1; data_in = 8'h01; #1;
        cmp("R1 phi2 low", "selects",
            24'({ram_rd, ram_wr, rom_rd, rom_we, bus_sel}), 24'd0);

        wr_ctrl(8'h3C);
        acc("R3 low64k to bus", 8'h00, 16'h1000, 1, 8'h00, ebus(24'h001000, 0), 1);
        acc("R6 bus write through", 8'h00, 16'h2000, 0, 8'h22, ewt(ebus(24'h002000, 0), 21'h002000), 1);
        acc("R4 R12 video read fast", 8'h00, 16'h8010, 1, 8'h00, eram(21'h008010, 1, 1), 1);
        acc("R4 video write remap", 8'h00, 16'h8010, 0, 8'h33, ewt(ebus(24'h018010, 0), 21'h008010), 1);
        acc("R5 io read", 8'h00, 16'hE900, 1, 8'h00, ebus(24'h00E900, 1), 1);

        // R2: alternate offset ignored without the relocate jumper
        acc("", 8'h00, 16'hEFFF, 0, 8'h00, ez(), 0);
        acc("R2 alt offset ignored", 8'h00, 16'h1000, 1, 8'h00, ebus(24'h001000, 0), 1);

        reloc_jmp = 1;
        wr_ctrl(8'h00);
        @(negedge clk); #1;
        cmp("R2 relocated write", "hide_bogus", 24'(hide_bogus), 24'd0);
        acc("R3 R13 low64k to ram", 8'h00, 16'h1000, 1, 8'h00, eram(21'h001000, 1, 0), 1);
        acc("R4 video read from bus", 8'h00, 16'h8010, 1, 8'h00, ebus(24'h018010, 0), 1);
        acc("R7 code 00 no block", 8'h00, 16'hF000, 0, 8'h44, eram(21'h00F000, 0, 0), 1);

        wr_ctrl(8'h01);
        acc("R7 code 01 blocked", 8'h00, 16'hA000, 0, 8'h55, ez(), 1);
        acc("R7 code 01 below", 8'h00, 16'h9FFF, 0, 8'h55, eram(21'h009FFF, 0, 0), 1);
        wr_ctrl(8'h02);
        acc("R7 code 10 blocked", 8'h00, 16'hC000, 0, 8'h55, ez(), 1);
        acc("R7 code 10 below", 8'h00, 16'hBFFF, 0, 8'h55, eram(21'h00BFFF, 0, 0), 1);
        wr_ctrl(8'h03);
        acc("R7 code 11 blocked", 8'h00, 16'hE000, 0, 8'h55, ez(), 1);
        acc("R7 code 11 below", 8'h00, 16'hDFFF, 0, 8'h55, eram(21'h00DFFF, 0, 0), 1);
        wr_ctrl(8'h23);
        acc("R6 R7 protected no through", 8'h00, 16'hF000, 0, 8'h66, ebus(24'h00F000, 0), 1);
        acc("R6 unprotected through", 8'h00, 16'h7000, 0, 8'h66, ewt(ebus(24'h007000, 0), 21'h007000), 1);

        wr_ctrl(8'h00);
        acc("R8 ram bank 0", 8'h01, 16'h2345, 1, 8'h00, eram(21'h012345, 1, 0), 1);
        acc("R8 ram bank 1", 8'h09, 16'h0000, 1, 8'h00, eram(21'h090000, 1, 0), 1);
        acc("R8 ram bank 2 top", 8'h17, 16'hFFFF, 0, 8'h77, eram(21'h17FFFF, 0, 0), 1);
        acc("R8 bus memory", 8'hE5, 16'h0000, 1, 8'h00, ebus(24'hE50000, 0), 1);
        acc("R9 mirror", 8'hF3, 16'h4567, 1, 8'h00, eram(21'h034567, 1, 0), 1);
        acc("R10 rom read", 8'hFA, 16'hBCDE, 1, 8'h00, erom(19'h2BCDE, 1, 0), 1);
        acc("R10 rom write locked", 8'hFA, 16'hBCDE, 0, 8'h88, erom(19'h2BCDE, 0, 0), 1);
        wr_ctrl(8'h80);
        acc("R10 rom write enabled", 8'hFA, 16'hBCDE, 0, 8'h88, erom(19'h2BCDE, 0, 1), 1);
        acc("R11 unmapped low", 8'h18, 16'h0000, 1, 8'h00, ez(), 1);
        acc("R11 unmapped high", 8'hDF, 16'hFFFF, 0, 8'h99, ez(), 1);
        wr_ctrl(8'h10);
        acc("R13 slow clock ram", 8'h01, 16'h0000, 1, 8'h00, eram(21'h010000, 1, 1), 1);
        wr_ctrl(8'h60);
        acc("R3 rom beats bus", 8'h00, 16'h4000, 1, 8'h00, erom(19'h04000, 1, 0), 1);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule